// File: doc/BRIEF.md
# Dual-Pattern Overlapping Sequence Detector

This block watches a serial bit stream and flags each bit that ends one of two complementary four-bit patterns. The patterns are 0110 and 1001, read oldest bit first. The flag is a Mealy output. It rises in the same cycle as the fourth bit of the pattern and is computed from that bit while the bit is still on the input. Detection runs without stopping. A hit does not clear the stored past, so two matches may share bits.

Bits enter through a valid/ready port, and each flag leaves through a valid/ready port. The output carries one flag for each input bit offered. The output is valid in exactly the cycles when an input bit is offered. The input is ready exactly when the output is ready, so back-pressure from downstream stalls the stream without loss. A stalled bit is not taken into the history, and the same flag stays on the output until the transfer completes. A synchronous reset empties the history. After a reset no flag can be raised until three bits have been accepted.

Top module: `dualpat_detect`

## Requirements
- R1: After reset, z_bit stays 0 for the first three accepted bits. For example, accepting 1,1,0 right after reset gives no flag, even though a cleared history padded with 0 would look like 0110.
- R2: When three bits have been accepted and the window {three accepted bits oldest first, x_bit} equals 0110, z_bit is 1 while x_valid is 1.
- R3: When three bits have been accepted and that window equals 1001, z_bit is 1 while x_valid is 1.
- R4: In every other case z_bit is 0.
- R5: Matches may overlap and a hit does not reset the history. For example, 0110110 flags its 4th and 7th bits, and 1001001 does the same.
- R6: z_valid equals x_valid. z_bit is 0 whenever x_valid is 0, and cycles with x_valid at 0 leave the history unchanged.
- R7: x_ready equals z_ready. A bit is taken into the history only in a cycle with x_valid and z_ready both 1. While the port is stalled, z_bit shows the flag for the bit currently offered.
- R8: rst is synchronous and active high. Asserting it mid-stream discards all history, and R1 applies again afterwards.
- R9: For the input 0011011100101011001100101 (first bit on the left, one bit accepted each cycle), z_bit is 0000100000100000101010100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_valid | input | 1 | Input bit offered |
| x_bit | input | 1 | Serial input bit |
| x_ready | output | 1 | Input bit can be accepted |
| z_valid | output | 1 | Flag on z_bit is valid |
| z_bit | output | 1 | Match flag for the offered bit |
| z_ready | input | 1 | Downstream accepts the flag |

## Verification
The bench targets three traps. A design that padded a cleared history with zeros would flag 1,1,0 right after reset. A design that cleared its history on a hit would miss the second flag of 0110110. A design that shifted on x_valid alone would absorb stalled or repeated bits and then flag in the wrong cycles. The bench also idles the input between the bits of a pattern and resets in the middle of a partial match. A design that let idle cycles or earlier bits leak into the window would show a flag that is missing or out of place.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  // Number of past bits kept; the window is these plus the live input.
  localparam int HIST_W = 3;
  localparam int WIN_W  = HIST_W + 1;
  localparam int NPAT   = 2;
  // Window layout: bit WIN_W-1 is the oldest bit, bit 0 the live input.
  localparam logic [NPAT-1:0][WIN_W-1:0] PATS = {4'b1001, 4'b0110};
endpackage

// File: rtl/dpd_history.sv
module dpd_history #(
  parameter int W = dpd_pkg::HIST_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist_o,
  output logic         full_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FILL_MAX = CW'(W);

  logic [W-1:0]  hist_q;
  logic [CW-1:0] fill_q;

  // Bit 0 holds the newest accepted bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (shift_en) begin
      hist_q <= {hist_q[W-2:0], bit_in};
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end

  assign hist_o = hist_q;
  assign full_o = (fill_q == FILL_MAX);
endmodule

// File: rtl/dpd_match.sv
module dpd_match #(
  parameter int W    = dpd_pkg::WIN_W,
  parameter int NPAT = dpd_pkg::NPAT
) (
  input  logic [W-1:0] window_i,
  output logic         hit_o
);
  logic [NPAT-1:0] hit_each;

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    assign hit_each[p] = (window_i == dpd_pkg::PATS[p]);
  end

  assign hit_o = |hit_each;
endmodule

// File: rtl/dualpat_detect.sv
module dualpat_detect #(
  parameter int HIST_W = dpd_pkg::HIST_W
) (
  input  logic clk,
  input  logic rst,
  input  logic x_valid,
  input  logic x_bit,
  output logic x_ready,
  output logic z_valid,
  output logic z_bit,
  input  logic z_ready
);
  localparam int WIN_W = HIST_W + 1;

  logic [HIST_W-1:0] hist;
  logic              full;
  logic              hit;
  logic              take;

  assign x_ready = z_ready;
  assign take    = x_valid & z_ready;

  dpd_history #(.W(HIST_W)) hist_i (
    .clk      (clk),
    .rst      (rst),
    .shift_en (take),
    .bit_in   (x_bit),
    .hist_o   (hist),
    .full_o   (full)
  );

  dpd_match #(.W(WIN_W), .NPAT(dpd_pkg::NPAT)) match_i (
    .window_i ({hist, x_bit}),
    .hit_o    (hit)
  );

  assign z_valid = x_valid;
  assign z_bit   = x_valid & full & hit;
endmodule

// File: rtl/dualpat_detect_chk.sv
module dualpat_detect_chk (
  input logic clk,
  input logic rst,
  input logic x_valid,
  input logic x_bit,
  input logic x_ready,
  input logic z_valid,
  input logic z_bit,
  input logic z_ready
);
  logic [1:0] seen;
  logic [2:0] last;   // last[0] is the most recent accepted bit
  logic       shape;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
      last <= '0;
    end else if (x_valid && x_ready) begin
      if (seen != 2'd3) seen <= seen + 2'd1;
      last <= {last[1:0], x_bit};
    end
  end

  // Both patterns: a flip at the ends, a repeat in the middle.
  assign shape = (x_bit != last[0]) && (last[0] == last[1]) && (last[1] != last[2]);

  assert_no_early_hit_R1: assert property (@(posedge clk) disable iff (rst)
    z_bit |-> (seen == 2'd3));

  // R2 and R3: a complete window of either shape must be flagged
  assert_hit_taken_R2: assert property (@(posedge clk) disable iff (rst)
    (x_valid && seen == 2'd3 && shape) |-> z_bit);

  assert_hit_shape_R4: assert property (@(posedge clk) disable iff (rst)
    z_bit |-> shape);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !x_valid |-> (!z_bit && !z_valid));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(x_valid && !z_ready) && x_valid && $stable(x_bit))
      |-> $stable(z_bit));
endmodule

bind dualpat_detect dualpat_detect_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .x_valid (x_valid),
  .x_bit   (x_bit),
  .x_ready (x_ready),
  .z_valid (z_valid),
  .z_bit   (z_bit),
  .z_ready (z_ready)
);

// File: tb/dualpat_detect_tb_top.sv
module dualpat_detect_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_valid = 1'b0;
  logic x_bit = 1'b0;
  logic z_ready = 1'b1;
  logic x_ready, z_valid, z_bit;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // Bench model of the requirements: accepted-bit count and last three bits.
  int       m_seen = 0;
  logic [2:0] m_hist = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualpat_detect dut_i (
    .clk(clk), .rst(rst), .x_valid(x_valid), .x_bit(x_bit),
    .x_ready(x_ready), .z_valid(z_valid), .z_bit(z_bit), .z_ready(z_ready)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic model_z(input logic v, input logic b);
    logic [3:0] w;
    w = {m_hist, b};
    return v && (m_seen >= 3) && (w == 4'b0110 || w == 4'b1001);
  endfunction

  // Drive one cycle, check the Mealy outputs before the coming edge.
  task automatic step(input logic v, input logic b, input logic rdy, input string req);
    @(negedge clk);
    x_valid = v; x_bit = b; z_ready = rdy;
    #1;
    chk(req, "z_bit", z_bit, model_z(v, b));
    chk("R6", "z_valid", z_valid, v);
    chk("R7", "x_ready", x_ready, rdy);
    if (v && rdy) begin
      m_hist = {m_hist[1:0], b};
      m_seen++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; x_valid = 1'b0; z_ready = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_seen = 0; m_hist = '0;
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    chk("R6", "z_valid after reset", z_valid, 1'b0);
    chk("R6", "z_bit after reset", z_bit, 1'b0);
    chk("R7", "x_ready after reset", x_ready, 1'b1);
  endtask

  task automatic t_early();
    do_reset();
    step(1, 1, 1, "R1");
    step(1, 1, 1, "R1");
    step(1, 0, 1, "R1");   // padded-zero window 0110 must not flag
    step(1, 0, 1, "R1");
    step(1, 1, 1, "R3");   // 1001 with four real bits
  endtask

  task automatic t_reference();
    logic [24:0] xs = 25'b0011011100101011001100101;
    logic [24:0] zs = 25'b0000100000100000101010100;
    do_reset();
    for (int i = 24; i >= 0; i--) begin
      @(negedge clk);
      x_valid = 1; x_bit = xs[i]; z_ready = 1;
      #1;
      chk("R9", "reference z", z_bit, zs[i]);
      m_hist = {m_hist[1:0], xs[i]}; m_seen++;
    end
  endtask

  task automatic t_overlap();
    logic [6:0] a = 7'b0110110;
    logic [6:0] b = 7'b1001001;
    do_reset();
    for (int i = 6; i >= 0; i--) begin
      @(negedge clk);
      x_valid = 1; x_bit = a[i]; z_ready = 1;
      #1;
      chk("R5", "overlap 0110110", z_bit, (i == 3 || i == 0));
      m_hist = {m_hist[1:0], a[i]}; m_seen++;
    end
    do_reset();
    for (int i = 6; i >= 0; i--) begin
      @(negedge clk);
      x_valid = 1; x_bit = b[i]; z_ready = 1;
      #1;
      chk("R5", "overlap 1001001", z_bit, (i == 3 || i == 0));
      m_hist = {m_hist[1:0], b[i]}; m_seen++;
    end
  endtask

  task automatic t_stall();
    do_reset();
    step(1, 0, 1, "R4");
    step(1, 1, 1, "R4");
    step(1, 1, 1, "R4");
    @(negedge clk); x_valid = 1; x_bit = 0; z_ready = 0; #1;
    chk("R7", "stalled flag shown", z_bit, 1'b1);
    chk("R7", "x_ready low in stall", x_ready, 1'b0);
    @(negedge clk); #1;
    chk("R7", "stalled flag held", z_bit, 1'b1);
    @(negedge clk); x_bit = 1; #1;
    chk("R7", "stalled other bit", z_bit, 1'b0);
    step(1, 1, 0, "R7");
    step(1, 0, 1, "R2");   // history still 011, so 0110 now
    step(1, 1, 1, "R4");
    step(1, 1, 1, "R4");
    step(1, 0, 1, "R2");
  endtask

  task automatic t_idle();
    do_reset();
    step(1, 1, 1, "R4");
    step(0, 0, 1, "R6");
    step(1, 0, 1, "R4");
    step(0, 1, 1, "R6");
    step(0, 0, 1, "R6");
    step(1, 0, 1, "R4");
    step(0, 1, 1, "R6");
    step(1, 1, 1, "R3");
  endtask

  task automatic t_midreset();
    do_reset();
    step(1, 0, 1, "R4");
    step(1, 1, 1, "R4");
    step(1, 1, 1, "R4");
    do_reset();
    step(1, 0, 1, "R8");   // old 011 must be gone
    step(1, 1, 1, "R8");
    step(1, 1, 1, "R8");
    step(1, 0, 1, "R8");
    chk("R8", "model flag after fresh 0110", model_z(1, 0), 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_early();
    t_reference();
    t_overlap();
    t_stall();
    t_idle();
    t_midreset();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule